// File: doc/BRIEF.md
# Step Tick Generator

This block takes the fast board clock and produces a slow system tick for logic that has to run at a rate a person can follow. The tick is a single-cycle clock-enable pulse in the fast clock domain, not a derived clock, so the logic downstream stays on one clock tree. With the default parameters a 50 MHz clock gives a 100 Hz tick.

A run-time switch selects one of two sources. With the switch low, a divider produces one tick every `CLK_HZ/TICK_HZ` fast cycles. With the switch high, the divider is held cleared and one tick is produced for each press of a push-button. The button is synchronised, debounced with a stable-level window of about 10 ms, and edge-detected. An LED output changes state on every tick, so single steps can be seen by eye.

Top module: `step_tick_gen`

## Requirements
- R1: During and right after reset, `tick_o` and `led_o` are both 0.
- R2: With `manual_i` = 0, `tick_o` pulses once every RATIO = `CLK_HZ/TICK_HZ` cycles, with exactly RATIO cycles from one pulse to the next.
- R3: When `manual_i` falls, the divider restarts from zero. The first tick is seen RATIO+2 clock edges after the first edge that samples the low switch level.
- R4: With `manual_i` = 1, the divider produces no ticks, and each accepted button press produces exactly one tick.
- R5: A new `button_i` level is accepted only after it has been stable for DEB = (`CLK_HZ`/1000)·`DEBOUNCE_MS` consecutive cycles. A level held for DEB cycles is accepted, one held for DEB-1 cycles is not, and bounce shorter than DEB produces no tick.
- R6: A button held down gives one tick only, and releasing it gives none.
- R7: With `manual_i` = 0, button activity produces no tick and does not change the tick spacing.
- R8: Changing the mode produces no extra tick. Entering manual mode with the button already held down produces none.
- R9: `led_o` changes state on the same edge on which `tick_o` rises, and holds its value at all other times.
- R10: `tick_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast board clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| manual_i | input | 1 | Mode switch, asynchronous: 0 selects the divider, 1 selects button stepping |
| button_i | input | 1 | Push-button, asynchronous, active high, may bounce |
| tick_o | output | 1 | Single-cycle tick enable |
| led_o | output | 1 | Indicator that changes state on every tick |

## Verification
The bench runs the block with a small ratio and a short debounce window. It sweeps every button pulse length from 1 to DEB-1 cycles and expects no tick, then applies a pulse of exactly DEB cycles and expects one. A debouncer that is off by one in either direction fails one of these two checks. Mixed bounce patterns, a long hold and a release catch a design that ticks on every accepted level change or re-triggers while the button is held. Mode changes are timed just after a divider tick, with the button held across the change. A divider that is not cleared would give the wrong first-tick latency, and an edge detector that does not see the mode would leak a step pulse into the divider's sequence or produce an extra tick on entering manual mode.

// File: rtl/step_tick_pkg.sv
`timescale 1ns/1ps
package step_tick_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_STEP = 1'b1
  } tick_mode_e;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/stk_sync.sv
`timescale 1ns/1ps
module stk_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[b] <= 1'b0;
        s2_q[b] <= 1'b0;
      end else begin
        s1_q[b] <= d_i[b];
        s2_q[b] <= s1_q[b];
      end
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/stk_debounce.sv
`timescale 1ns/1ps
module stk_debounce
  import step_tick_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic level_o,
  output logic rise_o
);
  localparam int unsigned CW = cnt_width(STABLE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  logic          state_q, rise_q;
  logic [CW-1:0] cnt_q;

  // a new level must differ from the held one on STABLE_CYCLES consecutive edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      rise_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      rise_q <= 1'b0;
      if (level_i == state_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        state_q <= level_i;
        rise_q  <= level_i;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = state_q;
  assign rise_o  = rise_q;
endmodule

// File: rtl/stk_divider.sv
`timescale 1ns/1ps
module stk_divider
  import step_tick_pkg::*;
#(
  parameter int unsigned RATIO = 500_000,
  localparam int unsigned CW   = cnt_width(RATIO)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          tick_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!en_i)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/step_tick_gen.sv
`timescale 1ns/1ps
module step_tick_gen
  import step_tick_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TICK_HZ     = 100,
  parameter int unsigned DEBOUNCE_MS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic manual_i,
  input  logic button_i,
  output logic tick_o,
  output logic led_o
);
  localparam int unsigned RATIO      = CLK_HZ / TICK_HZ;
  localparam int unsigned DEB_CYCLES = (CLK_HZ / 1000) * DEBOUNCE_MS;
  localparam int unsigned DIV_W      = cnt_width(RATIO);

  logic             manual_s, button_s;
  tick_mode_e       mode;
  logic             div_tick_w, press_w, btn_level_w, sel_w;
  logic [DIV_W-1:0] div_cnt_w;
  logic             tick_q, led_q;

  stk_sync #(.WIDTH(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({manual_i, button_i}),
    .q_o    ({manual_s, button_s})
  );

  assign mode = tick_mode_e'(manual_s);

  stk_divider #(.RATIO(RATIO)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode == MODE_RUN),
    .tick_o (div_tick_w),
    .cnt_o  (div_cnt_w)
  );

  stk_debounce #(.STABLE_CYCLES(DEB_CYCLES)) u_deb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (button_s),
    .level_o (btn_level_w),
    .rise_o  (press_w)
  );

  // press edges seen in run mode are dropped, so a held button never steps later
  assign sel_w = (mode == MODE_RUN) ? div_tick_w : press_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      led_q  <= 1'b0;
    end else begin
      tick_q <= sel_w;
      led_q  <= led_q ^ sel_w;
    end
  end

  assign tick_o = tick_q;
  assign led_o  = led_q;
endmodule

// File: rtl/step_tick_gen_chk.sv
`timescale 1ns/1ps
module step_tick_gen_chk #(
  parameter int unsigned RATIO = 2,
  parameter int unsigned CW    = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_o,
  input logic          led_o,
  input logic          manual_s,
  input logic          press,
  input logic [CW-1:0] div_cnt
);
  // R10
  tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R9
  led_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (led_o != $past(led_o)));

  // R9
  led_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(led_o));

  // R2
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_cnt <= CW'(RATIO - 1));

  // R4
  step_div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(manual_s) && manual_s) |-> (div_cnt == '0));

  // R7
  run_tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !$past(manual_s)) |-> ($past(div_cnt) == CW'(RATIO - 1)));

  // R4
  step_tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(manual_s)) |-> $past(press));
endmodule

bind step_tick_gen step_tick_gen_chk #(
  .RATIO (RATIO),
  .CW    (DIV_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_o   (tick_o),
  .led_o    (led_o),
  .manual_s (manual_s),
  .press    (press_w),
  .div_cnt  (div_cnt_w)
);

// File: tb/step_tick_gen_tb_top.sv
`timescale 1ns/1ps
module step_tick_gen_tb_top;
  localparam int CLK_HZ = 2000;
  localparam int TICK_HZ = 125;
  localparam int DMS = 10;
  localparam int DIV = CLK_HZ / TICK_HZ;        // 16
  localparam int DEB = (CLK_HZ / 1000) * DMS;   // 20

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic manual_i = 1'b1;
  logic button_i = 1'b0;
  logic tick_o, led_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tick_cnt = 0;
  int prev_tick_cyc = 0;
  bit have_prev = 0;
  bit spacing_en = 0;
  bit first_pend = 0;
  int first_cyc = 0;
  bit exp_led = 0;
  bit last_tick = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  step_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .DEBOUNCE_MS(DMS)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .manual_i(manual_i), .button_i(button_i),
    .tick_o(tick_o), .led_o(led_o)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor samples 1 ns after each rising edge
  always @(posedge clk_i) begin
    #1;
    cyc++;
    if (rst_ni) begin
      if (tick_o) begin
        tick_cnt++;
        exp_led = !exp_led;
        chk(!last_tick, "R10 back-to-back tick", 1, 0);
        if (spacing_en && have_prev)
          chk(cyc - prev_tick_cyc == DIV, "R2 tick spacing", cyc - prev_tick_cyc, DIV);
        if (first_pend) begin
          first_cyc  = cyc;
          first_pend = 0;
        end
        prev_tick_cyc = cyc;
        have_prev = 1;
      end
      if (led_o != exp_led) chk(0, "R9 led state", led_o, exp_led);
      last_tick = tick_o;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    int base, arm;
    step(3);
    chk(tick_o == 0, "R1 reset tick", tick_o, 0);
    chk(led_o == 0, "R1 reset led", led_o, 0);
    rst_ni = 1'b1;
    step(2);
    chk(tick_o == 0 && led_o == 0, "R1 after release", {tick_o, led_o}, 0);

    base = tick_cnt;
    step(4 * DIV);
    chk(tick_cnt == base, "R4 no divider tick in manual", tick_cnt - base, 0);

    // R5 sweep of pulses shorter than the window
    for (int len = 1; len < DEB; len++) begin
      base = tick_cnt;
      button_i = 1'b1; step(len);
      button_i = 1'b0; step(DEB + 5);
      chk(tick_cnt == base, $sformatf("R5 short pulse len=%0d", len), tick_cnt - base, 0);
    end
    base = tick_cnt;
    button_i = 1'b1; step(DEB);
    button_i = 1'b0; step(DEB + 5);
    chk(tick_cnt == base + 1, "R5 pulse of exactly DEB", tick_cnt - base, 1);

    // R6 long hold then release
    base = tick_cnt;
    button_i = 1'b1; step(5 * DEB);
    chk(tick_cnt == base + 1, "R6 hold gives one tick", tick_cnt - base, 1);
    base = tick_cnt;
    button_i = 1'b0; step(5 * DEB);
    chk(tick_cnt == base, "R6 release gives none", tick_cnt - base, 0);

    // R5 bounce around a press and a release
    base = tick_cnt;
    button_i = 1'b1; step(3);  button_i = 1'b0; step(2);
    button_i = 1'b1; step(7);  button_i = 1'b0; step(1);
    button_i = 1'b1; step(3 * DEB);
    button_i = 1'b0; step(4);  button_i = 1'b1; step(2);
    button_i = 1'b0; step(DEB - 2); button_i = 1'b1; step(3);
    button_i = 1'b0; step(3 * DEB);
    chk(tick_cnt == base + 1, "R5 bounce gives one tick", tick_cnt - base, 1);

    // R4 several clean presses
    base = tick_cnt;
    for (int p = 0; p < 3; p++) begin
      button_i = 1'b1; step(2 * DEB);
      button_i = 1'b0; step(2 * DEB);
    end
    chk(tick_cnt == base + 3, "R4 three presses", tick_cnt - base, 3);

    // R3 first tick after entering run mode
    manual_i = 1'b0; arm = cyc; first_pend = 1;
    step(DIV + 6);
    chk(first_pend == 0 && first_cyc - arm == DIV + 2, "R3 first tick latency", first_cyc - arm, DIV + 2);

    // R2 / R7 spacing with button activity
    spacing_en = 1;
    base = tick_cnt;
    button_i = 1'b1; step(3 * DEB);
    button_i = 1'b0; step(3 * DEB);
    button_i = 1'b1; step(5); button_i = 1'b0; step(DIV);
    button_i = 1'b1; step(2 * DEB);
    chk(tick_cnt - base >= (8 * DEB) / DIV - 1, "R7 run ticks continue", tick_cnt - base, (8 * DEB) / DIV);

    // R8 into manual just after a tick, button already held
    while (!tick_o) step(1);
    manual_i = 1'b1; spacing_en = 0;
    step(1);
    base = tick_cnt;
    step(4 * DIV);
    chk(tick_cnt == base, "R8 no tick entering manual with held button", tick_cnt - base, 0);
    button_i = 1'b0; step(2 * DEB);
    chk(tick_cnt == base, "R8 release after mode change", tick_cnt - base, 0);

    // R3 / R8 short run burst, back to manual, restart
    base = tick_cnt;
    manual_i = 1'b0; step(DIV / 2);
    manual_i = 1'b1; step(3);
    chk(tick_cnt == base, "R8 partial run burst no tick", tick_cnt - base, 0);
    manual_i = 1'b0; arm = cyc; first_pend = 1;
    step(DIV + 6);
    chk(first_pend == 0 && first_cyc - arm == DIV + 2, "R3 restart latency", first_cyc - arm, DIV + 2);
    chk(tick_cnt == base + 1, "R8 one tick after restart", tick_cnt - base, 1);

    spacing_en = 1;
    base = tick_cnt;
    step(5 * DIV);
    chk(tick_cnt == base + 5, "R2 tick count in five periods", tick_cnt - base, 5);

    done = 1;
    summary();
  end
endmodule